// File: doc/BRIEF.md
# Bipolar Violation Error Injector

This block sits in a transmit line path that uses alternate mark inversion (AMI). One unipolar data bit is taken in each time the bit-clock enable is high. It is turned into a pair of pulse outputs: one for a positive mark and one for a negative mark. In normal use every 1 is sent with the opposite polarity to the mark before it, and every 0 is sent as no pulse.

Software can ask for one deliberate bipolar violation as a line error test. A rising edge of the insert request arms the injector. The injector then waits until it sees a run of consecutive ones in the transmitted data. On the last one of that run, the mark is sent with the same polarity as the mark before it. The injector then disarms. Holding the request high does nothing more. The request must fall and rise again to arm the next violation. An `injected` output marks the bit period that carries the violation.

The design is one two-state machine plus a run counter and a polarity register.

- States: `ST_IDLE` (not armed) and `ST_ARMED` (waiting for the run).
- Transitions:
  - `ARM`: `ST_IDLE` to `ST_ARMED` on a request edge.
  - `COUNT`: stays in `ST_ARMED` on each strobed bit that does not fire.
  - `FIRE`: `ST_ARMED` to `ST_IDLE` on the violating bit.
  - `HOLD`: stays in the current state when there is neither an edge nor a firing bit.
- Parameter: `RUN_LEN` sets the run length. The default is 3, and it must be at least 2.

Top module: `bpv_injector`

## Requirements
- R1: Each strobed 1 that is not the violation is sent as a single pulse of opposite polarity to the previous mark. A strobed 0 is sent as no pulse. The first mark after reset is positive (`pos_out`=1, `neg_out`=0).
- R2: The outputs change only on the clock edge where `bit_en` is high, and they hold between strobes. `pos_out` and `neg_out` are never both 1. All outputs are 0 after reset.
- R3: A 0-to-1 change of `inject_req`, seen from one clock to the next, arms the injector. A request held at 1 never arms it again.
- R4: Once armed, the violation falls on the third consecutive strobed 1. A strobed 0 restarts the count. A strobed 1 in the same clock as the arming edge counts as the first 1 of the run.
- R5: The violating mark has the same polarity as the previous mark. Alternation then continues from the violating mark.
- R6: `injected` is 1 for exactly the bit period of the violating mark, and 0 otherwise.
- R7: A rising edge of `inject_req` while armed is ignored. This includes the clock in which the violation is sent.
- R8: The remembered request level is 0 after reset, so a request already at 1 when reset ends counts as a rising edge.
- R9: Exactly one violation (two consecutive marks of equal polarity) appears on the line for each accepted arming edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable; one data bit per high cycle |
| data_in | input | 1 | Unipolar transmit data bit |
| inject_req | input | 1 | Insert request; a rising edge arms one violation |
| pos_out | output | 1 | Positive mark pulse for the current bit period |
| neg_out | output | 1 | Negative mark pulse for the current bit period |
| injected | output | 1 | High during the bit period that carries the violation |

## Verification
Two of the block's functions can fall in the same clock: the arming edge, and the counting or firing of a strobed bit.

- Arming edge with a strobed 1: the bench raises `inject_req` in the same cycle as a strobed 1. It then expects the violation after only two further ones, because that 1 is counted (R4).
- Arming edge with the violating bit: the bench raises the request again in the exact cycle the violation is sent. It then drives a long run of ones and expects no second violation (R7).

A reference model in the bench predicts every pulse pair. A decoder on the outputs counts equal-polarity mark pairs and compares that count against the accepted edges.

// File: rtl/bpv_pkg.sv
package bpv_pkg;

    // Injector control states
    typedef enum logic {
        ST_IDLE  = 1'b0,   // not armed
        ST_ARMED = 1'b1    // armed, counting ones toward the violation
    } inj_state_t;

    // Line pulse pair for one bit period
    typedef struct packed {
        logic pos;
        logic neg;
    } pulse_t;

endpackage

// File: rtl/bpv_rise_detect.sv
module bpv_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);

    logic level_q;

    // Remembered level clears to 0, so a high level at reset release is an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_in;
        end
    end

    assign rise = level_in & ~level_q;

endmodule

// File: rtl/bpv_arm_fsm.sv
module bpv_arm_fsm
    import bpv_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic data_in,
    input  logic arm_edge,
    output logic armed,
    output logic fire
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RUN_LEN - 1);

    inj_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              one_bit;

    assign one_bit = bit_en & data_in;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state, run count and fire strobe
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_edge) begin                  // ARM
                    state_d = ST_ARMED;
                    cnt_d   = one_bit ? CNT_W'(1) : '0;
                end
            end
            ST_ARMED: begin                          // edges ignored here
                if (bit_en) begin
                    if (data_in && (cnt_q == LAST_IDX)) begin  // FIRE
                        fire    = 1'b1;
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else if (data_in) begin      // COUNT
                        cnt_d = cnt_q + CNT_W'(1);
                    end else begin
                        cnt_d = '0;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign armed = (state_q == ST_ARMED);

endmodule

// File: rtl/bpv_ami_encoder.sv
module bpv_ami_encoder
    import bpv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bit_en,
    input  logic   data_in,
    input  logic   violate,
    output pulse_t pulse,
    output logic   inj_flag
);

    logic   last_pos_q;   // polarity of the most recent mark, 1 = positive
    logic   mark_pos;
    pulse_t pulse_d;

    // Violation repeats the previous polarity, a normal mark flips it
    always_comb begin
        mark_pos = violate ? last_pos_q : ~last_pos_q;
        if (data_in) begin
            pulse_d.pos = mark_pos;
            pulse_d.neg = ~mark_pos;
        end else begin
            pulse_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_pos_q <= 1'b0;
            pulse      <= '0;
            inj_flag   <= 1'b0;
        end else if (bit_en) begin
            pulse    <= pulse_d;
            inj_flag <= violate;
            if (data_in) begin
                last_pos_q <= mark_pos;
            end
        end
    end

endmodule

// File: rtl/bpv_injector.sv
module bpv_injector
    import bpv_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic data_in,
    input  logic inject_req,
    output logic pos_out,
    output logic neg_out,
    output logic injected
);

    logic   req_rise;
    logic   armed;
    logic   fire;
    pulse_t pulse;

    bpv_rise_detect u_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (inject_req),
        .rise     (req_rise)
    );

    bpv_arm_fsm #(
        .RUN_LEN (RUN_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .data_in  (data_in),
        .arm_edge (req_rise),
        .armed    (armed),
        .fire     (fire)
    );

    bpv_ami_encoder u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .data_in  (data_in),
        .violate  (fire),
        .pulse    (pulse),
        .inj_flag (injected)
    );

    assign pos_out = pulse.pos;
    assign neg_out = pulse.neg;

endmodule

// File: rtl/bpv_injector_chk.sv
module bpv_injector_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic data_in,
    input logic inject_req,
    input logic pos_out,
    input logic neg_out,
    input logic injected,
    input logic armed
);

    logic past_ok;     // one clock seen since reset
    logic upd;         // outputs were refreshed at the last edge
    logic mark_pos_q;  // polarity of the last mark seen on the outputs

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok    <= 1'b0;
            upd        <= 1'b0;
            mark_pos_q <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            upd     <= bit_en;
            if (upd && (pos_out || neg_out)) begin
                mark_pos_q <= pos_out;
            end
        end
    end

    AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_out && neg_out)); // R2

    AST_HOLD_BETWEEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !upd) |-> $stable({pos_out, neg_out, injected})); // R2

    AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && upd && !$past(data_in)) |-> (!pos_out && !neg_out)); // R1

    AST_MARK_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (pos_out || neg_out)) |-> (pos_out == (injected ? mark_pos_q : !mark_pos_q))); // R5

    AST_ARM_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !armed && inject_req && !$past(inject_req)) |=> armed); // R3

    AST_INJ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && upd && injected) |-> ($past(armed) && (pos_out || neg_out))); // R6

endmodule

bind bpv_injector bpv_injector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .data_in    (data_in),
    .inject_req (inject_req),
    .pos_out    (pos_out),
    .neg_out    (neg_out),
    .injected   (injected),
    .armed      (armed)
);

// File: tb/tb_bpv_injector.sv
module tb_bpv_injector;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic data_in = 1'b0;
    logic inject_req = 1'b0;
    logic pos_out, neg_out, injected;

    always #5 clk = ~clk;

    bpv_injector dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_in(data_in),
        .inject_req(inject_req), .pos_out(pos_out), .neg_out(neg_out),
        .injected(injected)
    );

    typedef struct {
        logic  p;
        logic  n;
        logic  i;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    // Reference model state
    logic m_prev  = 1'b0;
    logic m_armed = 1'b0;
    int   m_cnt   = 0;
    logic m_last  = 1'b0;
    int   m_fires = 0;

    // Decoder state on observed outputs
    logic dec_last = 1'b0;
    int   dec_viol = 0;
    int   dec_inj  = 0;
    logic started  = 1'b0;

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: one clock per call; pushes the expected outputs for strobed bits
    task automatic step(input logic be, input logic d, input logic rq, input string tag);
        logic rise, fire, pol;
        exp_t e;
        @(negedge clk);
        bit_en = be; data_in = d; inject_req = rq;
        rise = rq && !m_prev;
        m_prev = rq;
        fire = 1'b0;
        if (m_armed) begin
            if (be) begin
                if (d && m_cnt == 2) begin
                    fire = 1'b1; m_armed = 1'b0; m_cnt = 0;
                end else begin
                    m_cnt = d ? m_cnt + 1 : 0;
                end
            end
        end else if (rise) begin
            m_armed = 1'b1;
            m_cnt = (be && d) ? 1 : 0;
        end
        if (be) begin
            if (d) begin
                pol = fire ? m_last : !m_last;
                m_last = pol;
                e = '{p: pol, n: !pol, i: fire, tag: tag};
            end else begin
                e = '{p: 1'b0, n: 1'b0, i: 1'b0, tag: tag};
            end
            if (fire) m_fires++;
            exp_q.push_back(e);
        end
    endtask

    task automatic ones(input int k, input logic rq, input string tag);
        for (int j = 0; j < k; j++) step(1'b1, 1'b1, rq, tag);
    endtask

    // Monitor: compare refreshed outputs, check holding otherwise
    initial begin
        logic cap;
        exp_t e;
        exp_t last_e;
        last_e = '{p: 1'b0, n: 1'b0, i: 1'b0, tag: "R2"};
        forever begin
            @(posedge clk);
            cap = bit_en && rst_n;
            @(negedge clk);
            if (cap && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(pos_out === e.p, e.tag, "pos_out", int'(pos_out), int'(e.p));
                check(neg_out === e.n, e.tag, "neg_out", int'(neg_out), int'(e.n));
                check(injected === e.i, (e.i ? "R6" : e.tag), "injected", int'(injected), int'(e.i));
                if (pos_out || neg_out) begin
                    if (pos_out == dec_last) dec_viol++;
                    dec_last = pos_out;
                end
                if (injected) dec_inj++;
                last_e = e;
            end else if (started && rst_n) begin
                check({pos_out, neg_out, injected} === {last_e.p, last_e.n, last_e.i},
                      "R2", "hold between strobes",
                      int'({pos_out, neg_out, injected}), int'({last_e.p, last_e.n, last_e.i}));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic        rq;
        // R8: request high through reset counts as an edge after release
        inject_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_prev = 1'b0;
        #1;
        check({pos_out, neg_out, injected} === 3'b000, "R2", "reset outputs",
              int'({pos_out, neg_out, injected}), 0);
        started = 1'b1;
        step(1'b0, 1'b0, 1'b1, "R8");
        ones(3, 1'b1, "R8");                // violation on third one
        // R3: request held at 1, long run, no second violation
        ones(6, 1'b1, "R3");
        step(1'b1, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R2");
        // R4: arm on a non-strobe cycle, zero restarts count
        step(1'b0, 1'b0, 1'b1, "R4");
        ones(2, 1'b1, "R4");
        step(1'b1, 1'b0, 1'b1, "R4");
        ones(3, 1'b0, "R4");
        ones(2, 1'b0, "R5");
        // R7: edge while armed is ignored
        step(1'b0, 1'b0, 1'b1, "R7");
        ones(1, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b1, "R7");
        ones(3, 1'b1, "R7");
        ones(4, 1'b0, "R7");
        // R4: edge in the same cycle as a strobed 1 counts it
        step(1'b1, 1'b1, 1'b1, "R4");
        ones(2, 1'b1, "R4");
        ones(3, 1'b0, "R4");
        // R7: edge coinciding with the violating bit is ignored
        step(1'b0, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b0, "R7");
        ones(2, 1'b0, "R7");
        step(1'b1, 1'b1, 1'b1, "R7");
        ones(5, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b0, "R1");
        // Pseudo-random traffic
        lfsr = 16'hACE1;
        rq = 1'b0;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[7:4] == 4'd0 || lfsr[7:4] == 4'd9) rq = !rq;
            step(lfsr[0] | lfsr[1], lfsr[2] | lfsr[5], rq, "R9");
        end
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, rq, "R2");
        // R9: one violation per accepted edge
        check(dec_viol == m_fires, "R9", "decoded violations", dec_viol, m_fires);
        check(dec_inj == m_fires, "R6", "injected pulses", dec_inj, m_fires);
        check(m_fires >= 6, "R9", "violations exercised", m_fires, 6);
        check(exp_q.size() == 0, "R2", "pending items", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule